// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Monitor

This block observes the command stream sent to a four-bank DDR SDRAM and flags every command that breaks a bank-state rule or a minimum spacing between commands. It keeps the open or idle state of each bank and a set of saturating "cycles since" counters per bank and for the whole device. Each spacing limit is a parameter counted in clock cycles.

Commands are decoded from the chip select, row strobe, column strobe and write enable pins on each rising edge. One registered error code results per sampled command, and a command that is flagged is not applied to the tracked state. Reads and writes use separate activate-to-column delays. Write recovery after an auto-precharge write is checked as one combined interval before the next activate. A read that would cut into a write burst still moving data is reported with its own code.

Top module: `ddrmon_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `err_valid` is 0, `err_code` is 0 and `bank_open` is 0000.
- R2: Pins decode as: `cs_n`=1 deselect; otherwise {`ras_n`,`cas_n`,`we_n`} 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop. Deselect and no-op never raise an error. Mode set and burst stop are only checked for the refresh interval.
- R3: An activate to an open bank gives code 2. A read or write to an idle bank gives code 3. Any flagged command leaves all tracked state, including `bank_open`, unchanged.
- R4: An activate to bank b gives code 5 if fewer than TRC cycles have passed since the last activate of b. It gives code 6 if fewer than TRP cycles have passed since b was closed by a precharge or a read with auto-precharge. It gives code 7 if b was closed by a write with auto-precharge and fewer than TDAL cycles have passed since that write's last data.
- R5: An activate less than TRRD cycles after an accepted activate to any bank gives code 4.
- R6: A read less than TRCDRD cycles after its bank's activate gives code 8. A write less than TRCDWR cycles after it gives code 9.
- R7: A read or write less than TCCD cycles after the previous accepted read or write gives code 10.
- R8: A read issued while the last write burst is still transferring gives code 11. A read issued after that burst but less than TCDLR cycles past its last data gives code 12.
- R9: A precharge with `ap`=0 to an open bank gives code 13 if fewer than TRAS cycles have passed since its activate. It gives code 14 if fewer than TWR cycles have passed since the last data of that bank's latest write. A precharge to an idle bank has no effect and no error.
- R10: A precharge with `ap`=1 applies the checks of R9 to every open bank, with code 13 taking precedence over code 14. If accepted, it closes all banks.
- R11: A refresh while any bank is open gives code 15. Any command other than deselect or no-op less than TRFC cycles after an accepted refresh gives code 1.
- R12: A read with `ap`=1 closes its bank when accepted, and TRP counts from the read. A write with `ap`=1 closes its bank and arms the TDAL check of R4.
- R13: The error for a command sampled at edge k shows on `err_valid`/`err_code` after edge k. Only one code is reported. Code 1 outranks all others. Activate order is 2,5,6,7,4. Read order is 3,8,10,11,12. Write order is 3,9,10.
- R14: `burst_sel` sampled with a write gives its burst length in clocks (half the beats): 0 gives 1, 1 gives 2, 2 or 3 gives 4. The last data of a write comes that many cycles after the write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | 2 | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| burst_sel | input | 2 | Configured burst length code |
| err_valid | output | 1 | Previous sampled command broke a rule |
| err_code | output | 4 | Code of the broken rule, 0 when none |
| bank_open | output | 4 | One bit per bank, 1 when the bank is open |

## Verification
The bench hits each limit exactly at the cycle the rule switches from failing to passing. A counter off by one then shows up as a flag on a legal command, or as silence on an illegal one. It places reads one cycle inside and one cycle past the write burst to separate the read-into-write code from the write-to-read recovery code. This catches a design that measures from the write command and not from the burst end. It also puts two violations on one command, such as row cycle together with auto-precharge recovery, or refresh interval together with a row rule, so that a wrong priority gives the wrong code. It sends precharges to idle banks and commands that are flagged, and then checks that `bank_open` and later checks behave as if those commands had never been issued.

// File: rtl/ddrmon_pkg.sv
`timescale 1ns/1ps
package ddrmon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_RFC      = 4'd1,
        ERR_ACT_OPEN = 4'd2,
        ERR_COL_IDLE = 4'd3,
        ERR_RRD      = 4'd4,
        ERR_RC       = 4'd5,
        ERR_RP       = 4'd6,
        ERR_DAL      = 4'd7,
        ERR_RCDRD    = 4'd8,
        ERR_RCDWR    = 4'd9,
        ERR_CCD      = 4'd10,
        ERR_RD_IN_WR = 4'd11,
        ERR_CDLR     = 4'd12,
        ERR_RAS      = 4'd13,
        ERR_WR       = 4'd14,
        ERR_REF_OPEN = 4'd15
    } err_e;

    // Per-bank spacing violations against the current cycle
    typedef struct packed {
        logic rc;
        logic rp;
        logic dal;
        logic rcdrd;
        logic rcdwr;
        logic ras;
        logic wr;
    } bank_viol_t;

    // Device-wide spacing violations against the current cycle
    typedef struct packed {
        logic rrd;
        logic ccd;
        logic rd_in_wr;
        logic cdlr;
        logic rfc;
    } glob_viol_t;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MRS;
                3'b110:  c = CMD_BST;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    // Clocks a write burst occupies after the write command
    function automatic logic [2:0] burst_clocks(input logic [1:0] sel);
        logic [2:0] h;
        case (sel)
            2'd0:    h = 3'd1;
            2'd1:    h = 3'd2;
            default: h = 3'd4;
        endcase
        return h;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddrmon_sat_cnt.sv
`timescale 1ns/1ps
module ddrmon_sat_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] SAT = '1;

    // Value = cycles since the last clr edge; saturates (reset = "long ago")
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= SAT;
        end else if (clr) begin
            cnt_o <= W'(1);
        end else if (cnt_o != SAT) begin
            cnt_o <= cnt_o + W'(1);
        end
    end
endmodule

// File: rtl/ddrmon_bank.sv
`timescale 1ns/1ps
module ddrmon_bank
    import ddrmon_pkg::*;
#(
    parameter int W      = 6,
    parameter int TRC    = 18,
    parameter int TRP    = 5,
    parameter int TRAS   = 13,
    parameter int TRCDRD = 6,
    parameter int TRCDWR = 4,
    parameter int TWR    = 4,
    parameter int TDAL   = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic       pre_i,
    input  logic       ap_i,
    input  logic [2:0] half_i,
    output logic       open_o,
    output bank_viol_t viol_o
);
    logic [W-1:0] act_cnt;
    logic [W-1:0] pre_cnt;
    logic [W-1:0] wr_cnt;
    logic [2:0]   half_q;
    logic         ap_pend;
    logic         close_pre;
    logic [W-1:0] half_w;

    assign close_pre = pre_i | (rd_i & ap_i);
    assign half_w    = W'(half_q);

    ddrmon_sat_cnt #(.W(W)) u_act_cnt (.clk(clk), .rst(rst), .clr(act_i),     .cnt_o(act_cnt));
    ddrmon_sat_cnt #(.W(W)) u_pre_cnt (.clk(clk), .rst(rst), .clr(close_pre), .cnt_o(pre_cnt));
    ddrmon_sat_cnt #(.W(W)) u_wr_cnt  (.clk(clk), .rst(rst), .clr(wr_i),      .cnt_o(wr_cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o  <= 1'b0;
            ap_pend <= 1'b0;
            half_q  <= 3'd0;
        end else begin
            if (act_i) begin
                open_o  <= 1'b1;
                ap_pend <= 1'b0;
            end else if (pre_i || ((rd_i || wr_i) && ap_i)) begin
                open_o <= 1'b0;
            end
            if (wr_i) begin
                half_q <= half_i;
                if (ap_i) begin
                    ap_pend <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        viol_o.rc    = act_cnt < W'(TRC);
        viol_o.rp    = pre_cnt < W'(TRP);
        viol_o.dal   = ap_pend && (wr_cnt < (W'(TDAL) + half_w));
        viol_o.rcdrd = act_cnt < W'(TRCDRD);
        viol_o.rcdwr = act_cnt < W'(TRCDWR);
        viol_o.ras   = act_cnt < W'(TRAS);
        viol_o.wr    = wr_cnt < (W'(TWR) + half_w);
    end
endmodule

// File: rtl/ddrmon_global.sv
`timescale 1ns/1ps
module ddrmon_global
    import ddrmon_pkg::*;
#(
    parameter int W     = 6,
    parameter int TRRD  = 4,
    parameter int TCCD  = 1,
    parameter int TCDLR = 3,
    parameter int TRFC  = 19
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act_i,
    input  logic       col_i,
    input  logic       wr_i,
    input  logic       ref_i,
    input  logic [2:0] half_i,
    output glob_viol_t viol_o
);
    logic [W-1:0] act_cnt;
    logic [W-1:0] col_cnt;
    logic [W-1:0] wr_cnt;
    logic [W-1:0] ref_cnt;
    logic [2:0]   ghalf;
    logic [W-1:0] ghalf_w;

    assign ghalf_w = W'(ghalf);

    ddrmon_sat_cnt #(.W(W)) u_rrd_cnt (.clk(clk), .rst(rst), .clr(act_i), .cnt_o(act_cnt));
    ddrmon_sat_cnt #(.W(W)) u_ccd_cnt (.clk(clk), .rst(rst), .clr(col_i), .cnt_o(col_cnt));
    ddrmon_sat_cnt #(.W(W)) u_gwr_cnt (.clk(clk), .rst(rst), .clr(wr_i),  .cnt_o(wr_cnt));
    ddrmon_sat_cnt #(.W(W)) u_rfc_cnt (.clk(clk), .rst(rst), .clr(ref_i), .cnt_o(ref_cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            ghalf <= 3'd0;
        end else if (wr_i) begin
            ghalf <= half_i;
        end
    end

    always_comb begin
        viol_o.rrd      = act_cnt < W'(TRRD);
        viol_o.ccd      = col_cnt < W'(TCCD);
        viol_o.rd_in_wr = wr_cnt < ghalf_w;
        viol_o.cdlr     = wr_cnt < (ghalf_w + W'(TCDLR));
        viol_o.rfc      = ref_cnt < W'(TRFC);
    end
endmodule

// File: rtl/ddrmon_top.sv
`timescale 1ns/1ps
module ddrmon_top
    import ddrmon_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int TRCDRD = 6,
    parameter int TRCDWR = 4,
    parameter int TRAS   = 13,
    parameter int TRC    = 18,
    parameter int TRRD   = 4,
    parameter int TRP    = 5,
    parameter int TWR    = 4,
    parameter int TCDLR  = 3,
    parameter int TDAL   = 9,
    parameter int TCCD   = 1,
    parameter int TRFC   = 19,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic             ap,
    input  logic [1:0]       burst_sel,
    output logic             err_valid,
    output logic [3:0]       err_code,
    output logic [NBANK-1:0] bank_open
);
    localparam int MAXLIM = imax(imax(imax(TRCDRD, TRCDWR), imax(TRAS, TRC)),
                                 imax(imax(imax(TRRD, TRP), imax(TWR, TCDLR)),
                                      imax(imax(TDAL, TCCD), TRFC)));
    localparam int CNT_W  = imax($clog2(MAXLIM + 5) + 1, 4);

    cmd_e                cmd;
    err_e                code;
    logic                ok;
    logic [2:0]          half;
    bank_viol_t          bv [NBANK];
    bank_viol_t          sel;
    glob_viol_t          gv;
    logic [NBANK-1:0]    open_v;
    logic                any_ras;
    logic                any_wr;

    assign cmd  = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign half = burst_clocks(burst_sel);
    assign sel  = bv[ba];

    // Rule selection with fixed priority
    always_comb begin
        any_ras = 1'b0;
        any_wr  = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (open_v[b]) begin
                any_ras = any_ras | bv[b].ras;
                any_wr  = any_wr  | bv[b].wr;
            end
        end
        code = ERR_NONE;
        if (cmd != CMD_NOP && gv.rfc) begin
            code = ERR_RFC;
        end else begin
            case (cmd)
                CMD_ACT: begin
                    if (open_v[ba])   code = ERR_ACT_OPEN;
                    else if (sel.rc)  code = ERR_RC;
                    else if (sel.rp)  code = ERR_RP;
                    else if (sel.dal) code = ERR_DAL;
                    else if (gv.rrd)  code = ERR_RRD;
                end
                CMD_RD: begin
                    if (!open_v[ba])       code = ERR_COL_IDLE;
                    else if (sel.rcdrd)    code = ERR_RCDRD;
                    else if (gv.ccd)       code = ERR_CCD;
                    else if (gv.rd_in_wr)  code = ERR_RD_IN_WR;
                    else if (gv.cdlr)      code = ERR_CDLR;
                end
                CMD_WR: begin
                    if (!open_v[ba])    code = ERR_COL_IDLE;
                    else if (sel.rcdwr) code = ERR_RCDWR;
                    else if (gv.ccd)    code = ERR_CCD;
                end
                CMD_PRE: begin
                    if (ap) begin
                        if (any_ras)     code = ERR_RAS;
                        else if (any_wr) code = ERR_WR;
                    end else if (open_v[ba]) begin
                        if (sel.ras)     code = ERR_RAS;
                        else if (sel.wr) code = ERR_WR;
                    end
                end
                CMD_REF: begin
                    if (|open_v) code = ERR_REF_OPEN;
                end
                default: code = ERR_NONE;
            endcase
        end
    end

    assign ok = (code == ERR_NONE);

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_bank
            logic hit;
            assign hit = ok && (ba == BA_W'(gb));
            ddrmon_bank #(
                .W(CNT_W), .TRC(TRC), .TRP(TRP), .TRAS(TRAS),
                .TRCDRD(TRCDRD), .TRCDWR(TRCDWR), .TWR(TWR), .TDAL(TDAL)
            ) u_bank (
                .clk    (clk),
                .rst    (rst),
                .act_i  (hit && cmd == CMD_ACT),
                .rd_i   (hit && cmd == CMD_RD),
                .wr_i   (hit && cmd == CMD_WR),
                .pre_i  (ok && cmd == CMD_PRE && (ap || ba == BA_W'(gb)) && open_v[gb]),
                .ap_i   (ap),
                .half_i (half),
                .open_o (open_v[gb]),
                .viol_o (bv[gb])
            );
        end
    endgenerate

    ddrmon_global #(
        .W(CNT_W), .TRRD(TRRD), .TCCD(TCCD), .TCDLR(TCDLR), .TRFC(TRFC)
    ) u_global (
        .clk    (clk),
        .rst    (rst),
        .act_i  (ok && cmd == CMD_ACT),
        .col_i  (ok && (cmd == CMD_RD || cmd == CMD_WR)),
        .wr_i   (ok && cmd == CMD_WR),
        .ref_i  (ok && cmd == CMD_REF),
        .half_i (half),
        .viol_o (gv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= 4'd0;
        end else begin
            err_valid <= !ok;
            err_code  <= code;
        end
    end

    assign bank_open = open_v;
endmodule

// File: rtl/ddrmon_chk.sv
`timescale 1ns/1ps
module ddrmon_chk
    import ddrmon_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BA_W = $clog2(NBANK)
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [BA_W-1:0]  ba,
    input logic             ap,
    input logic [1:0]       burst_sel,
    input logic             err_valid,
    input logic [3:0]       err_code,
    input logic [NBANK-1:0] bank_open
);
    cmd_e c;
    logic unused_sel;
    assign c = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign unused_sel = ^burst_sel;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!err_valid && bank_open == '0));

    // R2
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_NOP) |=> !err_valid);

    // R3
    act_open_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_ACT && bank_open[ba]) |=> err_valid);

    // R3
    col_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ((c == CMD_RD || c == CMD_WR) && !bank_open[ba]) |=> err_valid);

    // R3
    hold_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (bank_open == $past(bank_open)));

    // R10
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_PRE && ap) |=> (err_valid || bank_open == '0));

    // R11
    ref_open_chk: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_REF && |bank_open) |=>
            (err_valid && (err_code == ERR_REF_OPEN || err_code == ERR_RFC)));

    genvar gb;
    generate
        for (gb = 0; gb < NBANK; gb++) begin : g_open
            // R3
            open_src_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(bank_open[gb]) |-> $past(c == CMD_ACT && ba == BA_W'(gb)));
        end
    endgenerate
endmodule

bind ddrmon_top ddrmon_chk #(.NBANK(NBANK)) i_chk (.*);

// File: tb/test_ddrmon_top.sv
`timescale 1ns/1ps
module test_ddrmon_top;
    localparam int TRCDRD = 6, TRCDWR = 4, TRAS = 13, TRC = 18, TRRD = 4, TRP = 5;
    localparam int TWR = 4, TCDLR = 3, TDAL = 9, TCCD = 2, TRFC = 19;
    localparam int FAR = -100000;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4,
                   C_REF = 5, C_MRS = 6, C_BST = 7, C_DES = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0, bsel = 2'd1;
    logic ap = 1'b0;
    logic err_valid;
    logic [3:0] err_code;
    logic [3:0] bank_open;

    int total = 0, bad = 0, tcyc = 0;
    bit finished = 0;

    int  m_act[4], m_pre[4], m_wr[4], m_half[4];
    bit  m_open[4], m_append[4];
    int  m_anyact, m_col, m_gwr, m_ghalf, m_ref;

    always #10 clk = ~clk;

    ddrmon_top #(
        .NBANK(4), .TRCDRD(TRCDRD), .TRCDWR(TRCDWR), .TRAS(TRAS), .TRC(TRC),
        .TRRD(TRRD), .TRP(TRP), .TWR(TWR), .TCDLR(TCDLR), .TDAL(TDAL),
        .TCCD(TCCD), .TRFC(TRFC)
    ) i_ddrmon_top (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .ap(ap), .burst_sel(bsel),
        .err_valid(err_valid), .err_code(err_code), .bank_open(bank_open)
    );

    function automatic int hb(input int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    task automatic drive(input int c, input int b, input bit a);
        cs_n = (c == C_DES);
        case (c)
            C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            C_RD:    {ras_n, cas_n, we_n} = 3'b101;
            C_WR:    {ras_n, cas_n, we_n} = 3'b100;
            C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            C_REF:   {ras_n, cas_n, we_n} = 3'b001;
            C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
            C_BST:   {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        ba = 2'(b);
        ap = a;
    endtask

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, tcyc);
        end
    endtask

    // One command per cycle; output sampled 2 ns after the edge that took it
    task automatic step(input int c, input int b, input bit a, input int exp, input string tag);
        drive(c, b, a);
        @(posedge clk);
        #2;
        check(err_code == 4'(exp) && err_valid == (exp != 0), tag, int'(err_code), exp);
        tcyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(C_NOP, 0, 0, 0, "R2 no-op quiet");
    endtask

    task automatic check_open(input logic [3:0] exp, input string tag);
        check(bank_open == exp, tag, int'(bank_open), int'(exp));
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            m_act[k] = FAR; m_pre[k] = FAR; m_wr[k] = FAR; m_half[k] = 0;
            m_open[k] = 0; m_append[k] = 0;
        end
        m_anyact = FAR; m_col = FAR; m_gwr = FAR; m_ghalf = 0; m_ref = FAR;
    endtask

    function automatic int model_eval(input int c, input int b, input bit a, input int t);
        if (c != C_NOP && c != C_DES && t - m_ref < TRFC) return 1;
        case (c)
            C_ACT: begin
                if (m_open[b]) return 2;
                if (t - m_act[b] < TRC) return 5;
                if (t - m_pre[b] < TRP) return 6;
                if (m_append[b] && t - m_wr[b] < m_half[b] + TDAL) return 7;
                if (t - m_anyact < TRRD) return 4;
            end
            C_RD: begin
                if (!m_open[b]) return 3;
                if (t - m_act[b] < TRCDRD) return 8;
                if (t - m_col < TCCD) return 10;
                if (t - m_gwr < m_ghalf) return 11;
                if (t - m_gwr < m_ghalf + TCDLR) return 12;
            end
            C_WR: begin
                if (!m_open[b]) return 3;
                if (t - m_act[b] < TRCDWR) return 9;
                if (t - m_col < TCCD) return 10;
            end
            C_PRE: begin
                for (int k = 0; k < 4; k++)
                    if ((a || k == b) && m_open[k] && t - m_act[k] < TRAS) return 13;
                for (int k = 0; k < 4; k++)
                    if ((a || k == b) && m_open[k] && t - m_wr[k] < m_half[k] + TWR) return 14;
            end
            C_REF: begin
                for (int k = 0; k < 4; k++) if (m_open[k]) return 15;
            end
            default: ;
        endcase
        return 0;
    endfunction

    task automatic model_apply(input int c, input int b, input bit a, input int s, input int t);
        case (c)
            C_ACT: begin m_open[b] = 1; m_act[b] = t; m_append[b] = 0; m_anyact = t; end
            C_RD:  begin m_col = t; if (a) begin m_open[b] = 0; m_pre[b] = t; end end
            C_WR: begin
                m_col = t; m_wr[b] = t; m_half[b] = hb(s); m_gwr = t; m_ghalf = hb(s);
                if (a) begin m_open[b] = 0; m_append[b] = 1; end
            end
            C_PRE: begin
                for (int k = 0; k < 4; k++)
                    if ((a || k == b) && m_open[k]) begin m_open[k] = 0; m_pre[k] = t; end
            end
            C_REF: m_ref = t;
            default: ;
        endcase
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        drive(C_NOP, 0, 0);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        check(err_valid == 0 && err_code == 0, "R1 reset error outputs", int'(err_code), 0);
        check_open(4'b0000, "R1 reset bank_open");

        // Directed timeline; comments give the cycle index of each command
        bsel = 2'd1;
        step(C_ACT, 0, 0, 0,  "R4 first activate");                 // 0
        step(C_ACT, 0, 0, 2,  "R3 activate open bank");             // 1
        check_open(4'b0001, "R3 flagged command keeps state");
        step(C_RD,  0, 0, 8,  "R6 read before TRCDRD");             // 2
        step(C_WR,  0, 0, 9,  "R6 write before TRCDWR");            // 3
        step(C_WR,  0, 0, 0,  "R6 write at TRCDWR");                // 4
        step(C_WR,  0, 0, 10, "R7 column spacing");                 // 5
        step(C_RD,  0, 0, 12, "R8 read within write recovery");     // 6
        step(C_PRE, 0, 0, 13, "R9 precharge before TRAS");          // 7
        step(C_ACT, 1, 0, 0,  "R5 activate other bank");            // 8
        step(C_RD,  0, 0, 0,  "R8 read at recovery end (R14 half 2)"); // 9
        idle(1);                                                    // 10
        bsel = 2'd2;
        step(C_WR,  0, 0, 0,  "R7 column at TCCD");                 // 11
        idle(1);                                                    // 12
        step(C_RD,  0, 0, 11, "R8 read inside burst (R14 half 4)"); // 13
        step(C_PRE, 0, 0, 14, "R9 precharge before TWR");           // 14
        idle(4);                                                    // 15-18
        step(C_PRE, 0, 0, 0,  "R9 precharge at TWR");               // 19
        check_open(4'b0010, "R9 bank closed");
        step(C_ACT, 0, 0, 6,  "R4 activate before TRP");            // 20
        step(C_PRE, 2, 0, 0,  "R9 precharge idle bank");            // 21
        check_open(4'b0010, "R9 idle precharge no effect");
        idle(2);                                                    // 22-23
        step(C_ACT, 0, 0, 0,  "R4 activate at TRP");                // 24
        check_open(4'b0011, "R4 bank opened");
        step(C_PRE, 0, 1, 13, "R10 all-bank precharge TRAS");       // 25
        idle(11);                                                   // 26-36
        step(C_PRE, 3, 1, 0,  "R10 all-bank precharge accepted");   // 37
        check_open(4'b0000, "R10 all banks closed");
        step(C_REF, 0, 0, 0,  "R11 refresh all idle");              // 38
        step(C_ACT, 3, 0, 1,  "R11 command inside TRFC");           // 39
        step(C_DES, 0, 0, 0,  "R2 deselect quiet");                 // 40
        idle(16);                                                   // 41-56
        step(C_ACT, 3, 0, 0,  "R11 activate at TRFC");              // 57
        idle(5);                                                    // 58-62
        step(C_WR,  3, 1, 0,  "R12 write with auto-precharge");     // 63
        check_open(4'b0000, "R12 write auto-precharge closes");
        step(C_RD,  3, 0, 3,  "R3 read idle bank");                 // 64
        idle(10);                                                   // 65-74
        step(C_ACT, 3, 0, 7,  "R4 activate before TDAL");           // 75
        step(C_ACT, 3, 0, 0,  "R4 activate at TDAL");               // 76
        step(C_ACT, 2, 0, 4,  "R5 activate before TRRD");           // 77
        step(C_REF, 0, 0, 15, "R11 refresh with open bank");        // 78
        idle(3);                                                    // 79-81
        step(C_RD,  3, 1, 0,  "R12 read with auto-precharge");      // 82
        check_open(4'b0000, "R12 read auto-precharge closes");
        step(C_ACT, 3, 0, 5,  "R4 activate before TRC (R13 order)"); // 83

        // Random phase against the bench model
        rst = 1'b1;
        drive(C_NOP, 0, 0);
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        model_reset();
        tcyc = 0;
        for (int i = 0; i < 4000; i++) begin
            int r, c, b, e;
            bit a;
            r = int'($urandom % 100);
            c = (r < 55) ? C_NOP : (r < 60) ? C_DES : (r < 72) ? C_ACT :
                (r < 80) ? C_RD : (r < 88) ? C_WR : (r < 95) ? C_PRE :
                (r < 97) ? C_REF : (r < 99) ? C_MRS : C_BST;
            b = int'($urandom % 4);
            a = ($urandom % 4) == 0;
            bsel = 2'($urandom % 4);
            e = model_eval(c, b, a, tcyc);
            if (e == 0) model_apply(c, b, a, int'(bsel), tcyc);
            step(c, b, a, e, "R13 random stream code");
            check_open({3'(0), m_open[0]} | {2'(0), m_open[1], 1'b0} |
                       {1'b0, m_open[2], 2'b00} | {m_open[3], 3'b000},
                       "R3 random stream bank_open");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule